// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Output Latency

A true dual-port memory of 16-bit words. Each of its two ports, A and B, has its own clock and can read or write any word at any time, including the word the other port is using. Every control, address and data input is captured on the rising edge of that port's clock. The only exception is the output enable, which gates the output drivers directly. Each port can write its upper and lower byte separately. Each port also has two chip enables. The port is selected only when the first enable is low and the second is high.

The word address of a port comes from a small per-port address register. In any cycle that register can be cleared to zero, loaded from the address pins, advanced by one, or held. A static mode pin on each port sets the read latency. In flow-through mode, data for an address captured at edge k is on the bus just after edge k. In pipelined mode it appears one edge later, from an extra output register. A per-byte drive flag stands in for tri-state pads. Bytes that are not driven read as zero.

The depth is 2^`ADDR_W` words. `ADDR_W` = 16 gives the full 65536-word array. The default is 10, which keeps elaboration small. Memory contents are not cleared by reset.

Top module: `dpsram_top`

## Requirements
- R1: While reset is low and just after it is released, both drive flags of both ports are 0 and both address registers hold 0.
- R2: A port is selected at an edge only if its enable-0 input is low and its enable-1 input is high. An access captured while deselected writes nothing and drives no byte.
- R3: A write (read/write input low while selected) updates only the bytes whose active-low byte select is low. The upper select covers bits 15:8 and the lower select covers bits 7:0.
- R4: A read drives only the bytes whose byte select is low. Drive flag bit 1 is the upper byte and bit 0 is the lower byte. An undriven byte reads as 0.
- R5: In flow-through mode (mode pin 0), the word at the address captured at edge k is driven from just after edge k.
- R6: In pipelined mode (mode pin 1), the same word is driven from just after edge k+1.
- R7: In pipelined mode the chip enables pass through two register stages: one deselected edge leaves the outputs driven, and two take them off. In flow-through mode one stage applies. The byte selects pass through one stage in both modes.
- R8: The output enable is active-low and asynchronous. While it is high, both drive flags are 0 without any clock edge.
- R9: At each edge the address register takes, in falling priority, 0 if the clear input is low, the address pins if the load input is low, its value plus one (wrapping to 0) if the step input is low, and otherwise its old value. The address it takes is the one used by the access captured at that edge.
- R10: With load, step and clear inputs all high and no write to the word, a continuing read keeps the same data on the bus.
- R11: Both ports can read the same word in the same cycle. A word written by one port is read back by the other port.
- R12: When one port writes a word in the same cycle that the other port captures a read of it, the read returns the old contents. The new value appears from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset of the control registers |
| aPipeMode | input | 1 | Port A latency select: 0 flow-through, 1 pipelined |
| aEn0N | input | 1 | Port A chip enable, active low |
| aEn1 | input | 1 | Port A chip enable, active high |
| aRdWrN | input | 1 | Port A access type: 1 read, 0 write |
| aUpperN | input | 1 | Port A upper byte select, active low |
| aLowerN | input | 1 | Port A lower byte select, active low |
| aOeN | input | 1 | Port A asynchronous output enable, active low |
| aLoadN | input | 1 | Port A load address register from pins, active low |
| aStepN | input | 1 | Port A advance address register, active low |
| aClrN | input | 1 | Port A clear address register, active low |
| aAddr | input | ADDR_W | Port A address pins |
| aWrData | input | 16 | Port A write data |
| aRdData | output | 16 | Port A read data, undriven bytes zero |
| aDrive | output | 2 | Port A per-byte drive flags (bit 1 upper) |
| bPipeMode | input | 1 | Port B latency select |
| bEn0N | input | 1 | Port B chip enable, active low |
| bEn1 | input | 1 | Port B chip enable, active high |
| bRdWrN | input | 1 | Port B access type |
| bUpperN | input | 1 | Port B upper byte select, active low |
| bLowerN | input | 1 | Port B lower byte select, active low |
| bOeN | input | 1 | Port B asynchronous output enable, active low |
| bLoadN | input | 1 | Port B load address register, active low |
| bStepN | input | 1 | Port B advance address register, active low |
| bClrN | input | 1 | Port B clear address register, active low |
| bAddr | input | ADDR_W | Port B address pins |
| bWrData | input | 16 | Port B write data |
| bRdData | output | 16 | Port B read data, undriven bytes zero |
| bDrive | output | 2 | Port B per-byte drive flags |

## Verification
The hardest case to reach is a collision: one port's write commits to a word in the same cycle that the other port captures a read of that word. The stimulus sets this up deliberately. Port A issues a write to a word while port B, in flow-through mode, loads the same address in the same cycle. Port B then holds the address for one more edge, so that first the old word and then the new one must appear. A second hard case is the two-stage enable timing in pipelined mode. It is reached by dropping the chip enable for a single cycle and then for a longer stretch, in the middle of a steady pipelined read.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  localparam int BYTE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = BYTE_W * LANES;

  // strobes from a port controller to the storage datapath
  typedef struct packed {
    logic             wrEn;
    logic [LANES-1:0] laneWr;
    logic             pipeMode;
  } strobe_t;

  function automatic logic [WORD_W-1:0] laneMask(input logic [LANES-1:0] lanes);
    logic [WORD_W-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*BYTE_W +: BYTE_W] = {BYTE_W{lanes[l]}};
    return m;
  endfunction
endpackage

// File: rtl/dpram_addr_ctr.sv
module dpram_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              loadN,
  input  logic              stepN,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [ADDR_W-1:0] curAddr
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       curAddr <= '0;
    else if (!clrN)  curAddr <= '0;
    else if (!loadN) curAddr <= extAddr;
    else if (!stepN) curAddr <= curAddr + 1'b1;
  end

  // R9
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |=> (curAddr == '0));
  // R9
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && !loadN) |=> (curAddr == $past(extAddr)));
  // R9
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && loadN && !stepN) |=> (curAddr == ADDR_W'($past(curAddr) + 1'b1)));
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrN && loadN && stepN) |=> $stable(curAddr));
endmodule

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl import dpram_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeMode,
  input  logic              en0N,
  input  logic              en1,
  input  logic              rdWrN,
  input  logic              upperN,
  input  logic              lowerN,
  input  logic              oeN,
  input  logic              loadN,
  input  logic              stepN,
  input  logic              clrN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [WORD_W-1:0] wrData,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] accAddr,
  output logic [WORD_W-1:0] wrWord,
  output logic [LANES-1:0]  drive
);
  logic             selNow;
  logic             selQ1, selQ2, rdQ1, rdQ2;
  logic [LANES-1:0] laneQ;
  logic             slotRead;

  assign selNow = !en0N && en1;

  dpram_addr_ctr #(.ADDR_W(ADDR_W)) addrCtr_i (
    .clk(clk), .rstN(rstN), .clrN(clrN), .loadN(loadN), .stepN(stepN),
    .extAddr(extAddr), .curAddr(accAddr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ1 <= 1'b0;
      selQ2 <= 1'b0;
      rdQ1  <= 1'b0;
      rdQ2  <= 1'b0;
      laneQ <= '0;
    end else begin
      selQ1 <= selNow;
      selQ2 <= selQ1;
      rdQ1  <= rdWrN;
      rdQ2  <= rdQ1;
      laneQ <= ~{upperN, lowerN};
    end
  end

  always_ff @(posedge clk) wrWord <= wrData;

  assign strb.wrEn     = selQ1 && !rdQ1;
  assign strb.laneWr   = laneQ;
  assign strb.pipeMode = pipeMode;

  // enables take one stage in flow-through and two in pipelined; lanes one
  assign slotRead = pipeMode ? (selQ2 && rdQ2) : (selQ1 && rdQ1);
  assign drive    = laneQ & {LANES{slotRead && !oeN}};

  // R2
  desel_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> !strb.wrEn);
  // R7
  ft_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeMode && !selNow) |=> (drive == '0));
  // R7
  pipe_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pipeMode && !selNow) |=> ##1 (drive == '0));
  // R4
  no_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upperN && lowerN) |=> (drive == '0));
endmodule

// File: rtl/dpram_datapath.sv
module dpram_datapath import dpram_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic [1:0]        clk,
  input  strobe_t           strb   [2],
  input  logic [ADDR_W-1:0] addr   [2],
  input  logic [WORD_W-1:0] wrWord [2],
  input  logic [LANES-1:0]  drive  [2],
  output logic [WORD_W-1:0] rdData [2]
);
  localparam int DEPTH = 1 << ADDR_W;

  // bank p holds data ^ (other bank); the stored word is the XOR of both
  logic [1:0][WORD_W-1:0] atOwn;    // bank p at port p's address
  logic [1:0][WORD_W-1:0] atCross;  // bank p at the other port's address
  logic [1:0][WORD_W-1:0] rawWord;

  for (genvar p = 0; p < 2; p++) begin : gPort
    localparam int Q = 1 - p;
    logic [WORD_W-1:0] bank [DEPTH];
    logic [WORD_W-1:0] pipeReg;

    assign atOwn[p]   = bank[addr[p]];
    assign atCross[p] = bank[addr[Q]];
    assign rawWord[p] = atOwn[p] ^ atCross[Q];

    always_ff @(posedge clk[p]) begin
      if (strb[p].wrEn) begin
        for (int l = 0; l < LANES; l++) begin
          if (strb[p].laneWr[l])
            bank[addr[p]][l*BYTE_W +: BYTE_W] <=
              wrWord[p][l*BYTE_W +: BYTE_W] ^ atCross[Q][l*BYTE_W +: BYTE_W];
        end
      end
      pipeReg <= rawWord[p];
    end

    assign rdData[p] = (strb[p].pipeMode ? pipeReg : rawWord[p]) & laneMask(drive[p]);
  end
endmodule

// File: rtl/dpsram_top.sv
module dpsram_top import dpram_pkg::*; #(
  parameter int ADDR_W = 10
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              aPipeMode,
  input  logic              aEn0N,
  input  logic              aEn1,
  input  logic              aRdWrN,
  input  logic              aUpperN,
  input  logic              aLowerN,
  input  logic              aOeN,
  input  logic              aLoadN,
  input  logic              aStepN,
  input  logic              aClrN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [15:0]       aWrData,
  output logic [15:0]       aRdData,
  output logic [1:0]        aDrive,
  input  logic              bPipeMode,
  input  logic              bEn0N,
  input  logic              bEn1,
  input  logic              bRdWrN,
  input  logic              bUpperN,
  input  logic              bLowerN,
  input  logic              bOeN,
  input  logic              bLoadN,
  input  logic              bStepN,
  input  logic              bClrN,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [15:0]       bWrData,
  output logic [15:0]       bRdData,
  output logic [1:0]        bDrive
);
  logic [1:0] clkV, modeV, en0V, en1V, rwV, upV, loV, oeV, ldV, stV, clV;
  logic [ADDR_W-1:0] extAddrV [2];
  logic [ADDR_W-1:0] accAddrV [2];
  logic [WORD_W-1:0] wrDataV  [2];
  logic [WORD_W-1:0] wrWordV  [2];
  logic [WORD_W-1:0] rdDataV  [2];
  logic [LANES-1:0]  driveV   [2];
  strobe_t           strbV    [2];

  assign clkV  = {clkB, clkA};
  assign modeV = {bPipeMode, aPipeMode};
  assign en0V  = {bEn0N, aEn0N};
  assign en1V  = {bEn1, aEn1};
  assign rwV   = {bRdWrN, aRdWrN};
  assign upV   = {bUpperN, aUpperN};
  assign loV   = {bLowerN, aLowerN};
  assign oeV   = {bOeN, aOeN};
  assign ldV   = {bLoadN, aLoadN};
  assign stV   = {bStepN, aStepN};
  assign clV   = {bClrN, aClrN};
  assign extAddrV[0] = aAddr;
  assign extAddrV[1] = bAddr;
  assign wrDataV[0]  = aWrData;
  assign wrDataV[1]  = bWrData;

  for (genvar p = 0; p < 2; p++) begin : gCtrl
    dpram_port_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
      .clk(clkV[p]), .rstN(rstN), .pipeMode(modeV[p]),
      .en0N(en0V[p]), .en1(en1V[p]), .rdWrN(rwV[p]),
      .upperN(upV[p]), .lowerN(loV[p]), .oeN(oeV[p]),
      .loadN(ldV[p]), .stepN(stV[p]), .clrN(clV[p]),
      .extAddr(extAddrV[p]), .wrData(wrDataV[p]),
      .strb(strbV[p]), .accAddr(accAddrV[p]), .wrWord(wrWordV[p]),
      .drive(driveV[p])
    );
  end

  dpram_datapath #(.ADDR_W(ADDR_W)) data_i (
    .clk(clkV), .strb(strbV), .addr(accAddrV), .wrWord(wrWordV),
    .drive(driveV), .rdData(rdDataV)
  );

  assign aRdData = rdDataV[0];
  assign bRdData = rdDataV[1];
  assign aDrive  = driveV[0];
  assign bDrive  = driveV[1];
endmodule

// File: tb/dpsram_tb_top.sv
module dpsram_tb_top;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic mode[2], en0N[2], en1[2], rw[2], upN[2], loN[2], oeN[2], ldN[2], stN[2], clN[2];
  logic [AW-1:0] adr[2];
  logic [15:0]   wd[2];
  logic [15:0]   rdq[2];
  logic [1:0]    drv[2];

  dpsram_top #(.ADDR_W(AW)) dut_i (
    .clkA(clk), .clkB(clk), .rstN(rstN),
    .aPipeMode(mode[0]), .aEn0N(en0N[0]), .aEn1(en1[0]), .aRdWrN(rw[0]),
    .aUpperN(upN[0]), .aLowerN(loN[0]), .aOeN(oeN[0]), .aLoadN(ldN[0]),
    .aStepN(stN[0]), .aClrN(clN[0]), .aAddr(adr[0]), .aWrData(wd[0]),
    .aRdData(rdq[0]), .aDrive(drv[0]),
    .bPipeMode(mode[1]), .bEn0N(en0N[1]), .bEn1(en1[1]), .bRdWrN(rw[1]),
    .bUpperN(upN[1]), .bLowerN(loN[1]), .bOeN(oeN[1]), .bLoadN(ldN[1]),
    .bStepN(stN[1]), .bClrN(clN[1]), .bAddr(adr[1]), .bWrData(wd[1]),
    .bRdData(rdq[1]), .bDrive(drv[1])
  );

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  string reqTag = "R1";

  // behavioural reference state
  int        mAddr[2];
  bit        s1[2], s2[2], r1[2], r2[2];
  bit [1:0]  ln[2];
  bit        pw[2];
  int        pwAddr[2];
  bit [15:0] pwData[2];
  bit [1:0]  pwLn[2];
  bit [15:0] pipeD[2];
  bit [15:0] mem[DEPTH];

  function automatic logic [15:0] fillVal(int a);
    return 16'((a * 40503 + 499) & 32'hFFFF);
  endfunction

  task automatic modelEdge();
    bit [15:0] pre[2];
    for (int p = 0; p < 2; p++) pre[p] = mem[mAddr[p]];
    for (int p = 0; p < 2; p++)
      if (pw[p]) begin
        if (pwLn[p][1]) mem[pwAddr[p]][15:8] = pwData[p][15:8];
        if (pwLn[p][0]) mem[pwAddr[p]][7:0]  = pwData[p][7:0];
      end
    for (int p = 0; p < 2; p++) begin
      pipeD[p] = pre[p];
      s2[p] = s1[p];
      r2[p] = r1[p];
      s1[p] = !en0N[p] && en1[p];
      r1[p] = rw[p];
      ln[p] = ~{upN[p], loN[p]};
      if (!clN[p]) mAddr[p] = 0;
      else if (!ldN[p]) mAddr[p] = int'(adr[p]);
      else if (!stN[p]) mAddr[p] = (mAddr[p] + 1) % DEPTH;
      pw[p] = s1[p] && !r1[p];
      pwAddr[p] = mAddr[p];
      pwData[p] = wd[p];
      pwLn[p] = ln[p];
    end
  endtask

  task automatic compareAll();
    for (int p = 0; p < 2; p++) begin
      bit slot;
      bit [1:0] eDrv;
      bit [15:0] eDat;
      slot = mode[p] ? (s2[p] && r2[p]) : (s1[p] && r1[p]);
      eDrv = (slot && !oeN[p]) ? ln[p] : 2'b00;
      eDat = (mode[p] ? pipeD[p] : mem[mAddr[p]]) & {{8{eDrv[1]}}, {8{eDrv[0]}}};
      checks++;
      if (drv[p] !== eDrv || rdq[p] !== eDat) begin
        fails++;
        $display("FAIL %s port%0d model: drive act=%b exp=%b data act=%h exp=%h",
                 reqTag, p, drv[p], eDrv, rdq[p], eDat);
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    #2;
    compareAll();
  endtask

  task automatic chk(string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setIdle(int p);
    en0N[p] = 1'b1; en1[p] = 1'b1; rw[p] = 1'b1; upN[p] = 1'b0; loN[p] = 1'b0;
    ldN[p] = 1'b1; stN[p] = 1'b1; clN[p] = 1'b1;
  endtask

  task automatic setRead(int p, int a);
    en0N[p] = 1'b0; en1[p] = 1'b1; rw[p] = 1'b1; upN[p] = 1'b0; loN[p] = 1'b0;
    ldN[p] = 1'b0; stN[p] = 1'b1; clN[p] = 1'b1; adr[p] = AW'(a);
  endtask

  task automatic setWrite(int p, int a, logic [15:0] d, logic u, logic l);
    en0N[p] = 1'b0; en1[p] = 1'b1; rw[p] = 1'b0; upN[p] = u; loN[p] = l;
    ldN[p] = 1'b0; stN[p] = 1'b1; clN[p] = 1'b1; adr[p] = AW'(a); wd[p] = d;
  endtask

  task automatic setHold(int p);
    ldN[p] = 1'b1; stN[p] = 1'b1; clN[p] = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      fails++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) begin
      setIdle(p); mode[p] = 1'b0; oeN[p] = 1'b0; adr[p] = '0; wd[p] = '0;
      mAddr[p] = 0; s1[p] = 0; s2[p] = 0; r1[p] = 0; r2[p] = 0; ln[p] = 0;
      pw[p] = 0; pwAddr[p] = 0; pwData[p] = 0; pwLn[p] = 0; pipeD[p] = 0;
    end
    repeat (3) @(posedge clk);
    #2;
    // R1 during reset
    chk("R1 drive A in reset", {16'h0, drv[0]}, 18'h0);
    chk("R1 drive B in reset", {16'h0, drv[1]}, 18'h0);
    @(negedge clk) rstN = 1'b1;
    #1;
    chk("R1 drive A after reset", {16'h0, drv[0]}, 18'h0);
    chk("R1 drive B after reset", {16'h0, drv[1]}, 18'h0);

    // R9 fill every word through port A using load then step
    reqTag = "R9";
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 0) setWrite(0, 0, fillVal(0), 1'b0, 1'b0);
      else begin ldN[0] = 1'b1; stN[0] = 1'b0; wd[0] = fillVal(i); end
      cycle();
    end
    setIdle(0);
    cycle();

    // R5 flow-through reads on both ports
    reqTag = "R5";
    setRead(0, 5); setRead(1, 900);
    cycle();
    chk("R5 A word 5", {drv[0], rdq[0]}, {2'b11, fillVal(5)});
    chk("R5 B word 900", {drv[1], rdq[1]}, {2'b11, fillVal(900)});
    setRead(0, 17);
    cycle();
    chk("R5 A word 17", {drv[0], rdq[0]}, {2'b11, fillVal(17)});
    setIdle(0); setIdle(1);
    repeat (3) cycle();

    // R6 pipelined latency on B
    reqTag = "R6";
    mode[1] = 1'b1;
    repeat (3) cycle();
    setRead(1, 33);
    cycle();
    chk("R6 B not yet driven", {16'h0, drv[1]}, 18'h0);
    cycle();
    chk("R6 B word 33", {drv[1], rdq[1]}, {2'b11, fillVal(33)});

    // R7 pipelined enable staging and single-stage byte selects
    reqTag = "R7";
    cycle();
    en0N[1] = 1'b1;
    cycle();
    chk("R7 pipe one deselect edge still driven", {16'h0, drv[1]}, {16'h0, 2'b11});
    cycle();
    chk("R7 pipe two deselect edges off", {16'h0, drv[1]}, 18'h0);
    en0N[1] = 1'b0;
    cycle();
    chk("R7 pipe one select edge still off", {16'h0, drv[1]}, 18'h0);
    cycle();
    chk("R7 pipe reactivated", {drv[1], rdq[1]}, {2'b11, fillVal(33)});
    upN[1] = 1'b1;
    cycle();
    chk("R7 byte select one stage in pipe", {drv[1], rdq[1]}, {2'b01, 8'h00, fillVal(33)[7:0]});
    setIdle(1);
    // flow-through single stage on A
    setRead(0, 6);
    cycle();
    en1[0] = 1'b0;
    cycle();
    chk("R7 flow-through deselect one edge", {16'h0, drv[0]}, 18'h0);

    // R3 upper-only write
    reqTag = "R3";
    setWrite(0, 40, 16'h1234, 1'b0, 1'b1);
    cycle();
    setRead(0, 40);
    cycle();
    chk("R3 upper byte written only", {drv[0], rdq[0]}, {2'b11, 8'h12, fillVal(40)[7:0]});
    setWrite(0, 40, 16'hABCD, 1'b1, 1'b0);
    cycle();
    setRead(0, 40);
    cycle();
    chk("R3 lower byte written only", {drv[0], rdq[0]}, {2'b11, 16'h12CD});

    // R4 lane-selected reads
    reqTag = "R4";
    upN[0] = 1'b1; loN[0] = 1'b0;
    cycle();
    chk("R4 lower lane only", {drv[0], rdq[0]}, {2'b01, 16'h00CD});
    upN[0] = 1'b0; loN[0] = 1'b1;
    cycle();
    chk("R4 upper lane only", {drv[0], rdq[0]}, {2'b10, 16'h1200});
    upN[0] = 1'b1;
    cycle();
    chk("R4 no lane", {drv[0], rdq[0]}, 18'h0);

    // R2 writes while deselected
    reqTag = "R2";
    setWrite(0, 41, 16'hFFFF, 1'b0, 1'b0); en1[0] = 1'b0;
    cycle();
    chk("R2 deselected by enable 1", {16'h0, drv[0]}, 18'h0);
    en1[0] = 1'b1; en0N[0] = 1'b1;
    cycle();
    en0N[0] = 1'b1; en1[0] = 1'b0;
    cycle();
    setRead(0, 41);
    cycle();
    chk("R2 word untouched", {drv[0], rdq[0]}, {2'b11, fillVal(41)});
    en0N[0] = 1'b1; setHold(0);
    cycle();
    chk("R2 deselected read not driven", {16'h0, drv[0]}, 18'h0);

    // R8 asynchronous output enable
    reqTag = "R8";
    setRead(0, 5);
    cycle();
    #1 oeN[0] = 1'b1;
    #1 chk("R8 oe high no edge", {drv[0], rdq[0]}, 18'h0);
    oeN[0] = 1'b0;
    #1 chk("R8 oe low no edge", {drv[0], rdq[0]}, {2'b11, fillVal(5)});

    // R9 address register priority and wrap, R10 hold
    reqTag = "R9";
    setRead(0, 77); clN[0] = 1'b0;
    cycle();
    chk("R9 clear beats load", {drv[0], rdq[0]}, {2'b11, fillVal(0)});
    clN[0] = 1'b1; stN[0] = 1'b0;
    cycle();
    chk("R9 load beats step", {drv[0], rdq[0]}, {2'b11, fillVal(77)});
    ldN[0] = 1'b1;
    cycle();
    chk("R9 step", {drv[0], rdq[0]}, {2'b11, fillVal(78)});
    reqTag = "R10";
    stN[0] = 1'b1;
    cycle();
    chk("R10 hold one", {drv[0], rdq[0]}, {2'b11, fillVal(78)});
    cycle();
    chk("R10 hold two", {drv[0], rdq[0]}, {2'b11, fillVal(78)});
    reqTag = "R9";
    setRead(0, DEPTH - 1);
    cycle();
    ldN[0] = 1'b1; stN[0] = 1'b0;
    cycle();
    chk("R9 wrap to 0", {drv[0], rdq[0]}, {2'b11, fillVal(0)});

    // R11 both ports same word, cross-port write visibility
    reqTag = "R11";
    setRead(0, 100); setRead(1, 100);
    cycle();
    chk("R11 A same word", {drv[0], rdq[0]}, {2'b11, fillVal(100)});
    cycle();
    chk("R11 B same word", {drv[1], rdq[1]}, {2'b11, fillVal(100)});
    setIdle(0);
    setWrite(1, 100, 16'hBEEF, 1'b0, 1'b0);
    cycle();
    setIdle(1);
    setRead(0, 100);
    cycle();
    chk("R11 A sees B write", {drv[0], rdq[0]}, {2'b11, 16'hBEEF});

    // R12 collision
    reqTag = "R12";
    setIdle(0);
    repeat (3) cycle();
    mode[1] = 1'b0;
    repeat (3) cycle();
    setWrite(0, 200, 16'h5555, 1'b0, 1'b0);
    setRead(1, 200);
    cycle();
    chk("R12 old contents in collision", {drv[1], rdq[1]}, {2'b11, fillVal(200)});
    setIdle(0); setHold(1);
    cycle();
    chk("R12 new contents next edge", {drv[1], rdq[1]}, {2'b11, 16'h5555});
    setIdle(1);
    repeat (2) cycle();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule